// File: doc/BRIEF.md
# Device Ready-Wait Poller

This block waits for a storage device to become ready. A start pulse gives it a bit mask and a unit number. The block then polls the device's non-clearing status byte through a one-byte read port. Reading that copy of the status does not acknowledge a pending interrupt. Time is counted in microseconds from an external tick.

The wait has two phases:

- **Busy phase.** The block waits for the BUSY bit to drop. It polls at a fine interval at first and at a coarse interval once the accounted time passes a threshold. A read of all ones means nothing is driving the bus. In that case the block writes the drive-select byte again, charges a time penalty and waits before it polls again.
- **Mask phase.** This phase runs only when the mask is nonzero. The block makes a bounded number of reads until every mask bit is set.

The block ends with a one-cycle done pulse and a 3-bit two's-complement result. The result is either the status ERROR bit or one of two timeout codes. A controller sequencer uses it before it issues a command and between data blocks.

Top module: `ready_wait_poller`

## Requirements
- R1: A `start` pulse while idle latches `start_mask` and `start_unit`. `busy` is high from the next cycle until the cycle in which `done` is high. `done` is a one-cycle pulse, and `busy` is low in that cycle.
- R2: The first status read comes SETTLE_US (1) ticks after start. Each read is a one-cycle `stat_rd` strobe, and the block samples `stat_data` in the following cycle. Nothing is read or written while idle.
- R3: In the busy phase, a read with BUSY (bit 7) set adds an interval to the accounted time and waits that many ticks. The interval is FINE_STEP_US (10) while the accounted time is at most FINE_LIMIT_US (1000). Otherwise it is COARSE_STEP_US (1000).
- R4: A read of 8'hFF in the busy phase is handled as follows:
  - It causes one `dsel_wr` strobe with `dsel_data` = 8'hA0 | (unit << 4).
  - It adds FLOAT_PENALTY_US (1000) to the accounted time.
  - The block waits FLOAT_WAIT_US (1000) ticks before the next budget check.
- R5: Before every busy-phase read, the block checks the accounted time. At or above BUSY_BUDGET_US (1,000,000) it finishes with result -2 (3'b110).
- R6: If a busy-phase read has BUSY clear and the mask is zero, the block finishes with result equal to status bit 0 (ERROR), zero-extended.
- R7: With a nonzero mask, after BUSY clears the block waits SETTLE_US ticks. It then reads up to MASK_TRIES (5000) times, MASK_STEP_US (10) ticks apart. It finishes on the first read where (status & mask) == mask, and the result is that read's bit 0.
- R8: If no mask-phase read satisfies the mask, the block waits the step after the last read and then finishes with result -3 (3'b101).
- R9: A `start` pulse while `busy` is high is ignored. The result, the read count and the timing of the running wait do not change.
- R10: Reset returns the block to idle with `busy`, `done`, `stat_rd` and `dsel_wr` low. An interrupted wait produces no done pulse and no further reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse per elapsed microsecond |
| start | input | 1 | Begin a wait (ignored while busy) |
| start_mask | input | 8 | Status bits required in the mask phase; zero skips that phase |
| start_unit | input | 1 | Device unit number used in drive-select writes |
| stat_rd | output | 1 | Strobe that reads the non-clearing status byte |
| stat_data | input | 8 | Status byte, sampled the cycle after `stat_rd` |
| dsel_wr | output | 1 | Strobe that writes the drive-select byte |
| dsel_data | output | 8 | Drive-select byte |
| busy | output | 1 | A wait is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | Signed result: ERROR bit, -2 busy timeout, -3 mask timeout; valid with `done` |

## Verification
The bench targets several corner cases; for each, the failure a wrong design would show is given.

- **Fine-to-coarse switch.** A busy stretch crosses the threshold. A design that compares with `>=` instead of `>`, or that adds the wrong interval, changes the total tick count from start to done.
- **Floating bus, first case.** A run of 8'hFF reads checks that every such read gives exactly one drive-select write with the right unit bit.
- **Floating bus, second case.** An endless 8'hFF run must still reach the busy timeout. A design that skips the budget check after a penalty would hang here.
- **Mask phase.** The bench checks that partial matches are rejected and that the ERROR bit of the matching read is returned. The -3 code must arrive only after the full number of reads.
- **Restart and reset.** A second start during a wait, and a reset in the middle of a wait, must leave no trace in the read count or the done pulses.

// File: rtl/ready_wait_poller.sv
module ready_wait_poller #(
  parameter int BUSY_BUDGET_US   = 1000000,
  parameter int FINE_LIMIT_US    = 1000,
  parameter int FINE_STEP_US     = 10,
  parameter int COARSE_STEP_US   = 1000,
  parameter int FLOAT_PENALTY_US = 1000,
  parameter int FLOAT_WAIT_US    = 1000,
  parameter int MASK_TRIES       = 5000,
  parameter int MASK_STEP_US     = 10,
  parameter int SETTLE_US        = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic       start,
  input  logic [7:0] start_mask,
  input  logic       start_unit,
  output logic       stat_rd,
  input  logic [7:0] stat_data,
  output logic       dsel_wr,
  output logic [7:0] dsel_data,
  output logic       busy,
  output logic       done,
  output logic [2:0] result
);

  localparam int M1    = (FINE_STEP_US > COARSE_STEP_US) ? FINE_STEP_US : COARSE_STEP_US;
  localparam int M2    = (M1 > FLOAT_WAIT_US) ? M1 : FLOAT_WAIT_US;
  localparam int M3    = (M2 > MASK_STEP_US) ? M2 : MASK_STEP_US;
  localparam int MAXD  = (M3 > SETTLE_US) ? M3 : SETTLE_US;
  localparam int DLY_W = $clog2(MAXD + 1);
  localparam int ACC_W = $clog2(BUSY_BUDGET_US + MAXD + FLOAT_PENALTY_US + 1);
  localparam int TRY_W = $clog2(MASK_TRIES + 1);

  localparam logic [2:0] RES_BUSY_TO = 3'b110;
  localparam logic [2:0] RES_MASK_TO = 3'b101;
  localparam logic [7:0] FLOAT_VAL   = 8'hFF;

  typedef enum logic [3:0] {
    S_IDLE, S_WAIT_B, S_RD_B, S_CAP_B, S_SEL, S_WAIT_M, S_RD_M, S_CAP_M
  } st_t;

  st_t              state;
  logic [ACC_W-1:0] acc;
  logic [DLY_W-1:0] dly;
  logic [TRY_W-1:0] tries;
  logic [7:0]       mask_q;
  logic             unit_q;
  logic             done_q;
  logic [2:0]       res_q;

  wire in_wait  = (state == S_WAIT_B) || (state == S_WAIT_M);
  wire dly_zero = (dly == '0);
  wire mask_hit = (stat_data & mask_q) == mask_q;

  assign busy      = (state != S_IDLE);
  assign stat_rd   = (state == S_RD_B) || (state == S_RD_M);
  assign dsel_wr   = (state == S_SEL);
  assign dsel_data = 8'hA0 | {3'b000, unit_q, 4'b0000};
  assign done      = done_q;
  assign result    = res_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      acc    <= '0;
      dly    <= '0;
      tries  <= '0;
      mask_q <= '0;
      unit_q <= 1'b0;
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (in_wait && us_tick && !dly_zero) dly <= dly - DLY_W'(1);
      case (state)
        S_IDLE: if (start) begin
          mask_q <= start_mask;
          unit_q <= start_unit;
          acc    <= '0;
          tries  <= '0;
          dly    <= DLY_W'(SETTLE_US);
          state  <= S_WAIT_B;
        end
        S_WAIT_B: if (dly_zero) begin
          if (acc >= ACC_W'(BUSY_BUDGET_US)) begin
            res_q  <= RES_BUSY_TO;
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else begin
            state <= S_RD_B;
          end
        end
        S_RD_B: state <= S_CAP_B;
        S_CAP_B: begin
          if (stat_data == FLOAT_VAL) begin
            state <= S_SEL;
          end else if (!stat_data[7]) begin
            if (mask_q == 8'h00) begin
              res_q  <= {2'b00, stat_data[0]};
              done_q <= 1'b1;
              state  <= S_IDLE;
            end else begin
              dly   <= DLY_W'(SETTLE_US);
              state <= S_WAIT_M;
            end
          end else if (acc > ACC_W'(FINE_LIMIT_US)) begin
            acc   <= acc + ACC_W'(COARSE_STEP_US);
            dly   <= DLY_W'(COARSE_STEP_US);
            state <= S_WAIT_B;
          end else begin
            acc   <= acc + ACC_W'(FINE_STEP_US);
            dly   <= DLY_W'(FINE_STEP_US);
            state <= S_WAIT_B;
          end
        end
        S_SEL: begin
          acc   <= acc + ACC_W'(FLOAT_PENALTY_US);
          dly   <= DLY_W'(FLOAT_WAIT_US);
          state <= S_WAIT_B;
        end
        S_WAIT_M: if (dly_zero) begin
          if (tries == TRY_W'(MASK_TRIES)) begin
            res_q  <= RES_MASK_TO;
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else begin
            state <= S_RD_M;
          end
        end
        S_RD_M: state <= S_CAP_M;
        S_CAP_M: begin
          if (mask_hit) begin
            res_q  <= {2'b00, stat_data[0]};
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else begin
            tries <= tries + TRY_W'(1);
            dly   <= DLY_W'(MASK_STEP_US);
            state <= S_WAIT_M;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_ends_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  p_start_taken_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !stat_rd && !dsel_wr);
  p_read_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> !stat_rd && busy);
  p_sel_then_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dsel_wr |=> busy && !stat_rd && !dsel_wr);
  p_legal_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result == 3'b000 || result == 3'b001 ||
              result == RES_BUSY_TO || result == RES_MASK_TO));
  p_busy_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> (busy || done));

endmodule

// File: tb/tb_ready_wait_poller.sv
module tb_ready_wait_poller;

  localparam int BUDGET = 3000;
  localparam int FLIM   = 100;
  localparam int FSTEP  = 10;
  localparam int CSTEP  = 500;
  localparam int PEN    = 500;
  localparam int FWAIT  = 500;
  localparam int TRIES  = 20;
  localparam int MSTEP  = 10;
  localparam int SETTLE = 1;
  localparam int NV     = 10;

  // {unit[63:56], mask[55:48], busy_cnt[47:36], busy_val[35:28],
  //  fail_cnt[27:16], fail_val[15:8], good_val[7:0]}
  localparam bit [63:0] VEC [NV] = '{
    {8'd0, 8'h00, 12'd0,    8'h80, 12'd0,   8'h00, 8'h50},
    {8'd0, 8'h00, 12'd3,    8'h80, 12'd0,   8'h00, 8'h51},
    {8'd0, 8'h48, 12'd2,    8'h80, 12'd4,   8'h50, 8'h58},
    {8'd1, 8'h48, 12'd0,    8'h80, 12'd2,   8'h40, 8'h49},
    {8'd0, 8'h08, 12'd15,   8'hD0, 12'd0,   8'h00, 8'h58},
    {8'd1, 8'h00, 12'd3,    8'hFF, 12'd0,   8'h00, 8'h50},
    {8'd0, 8'h08, 12'd0,    8'h80, 12'd100, 8'h50, 8'h58},
    {8'd0, 8'h00, 12'd4000, 8'h80, 12'd0,   8'h00, 8'h50},
    {8'd1, 8'h00, 12'd4000, 8'hFF, 12'd0,   8'h00, 8'h50},
    {8'd0, 8'h41, 12'd2,    8'hFF, 12'd1,   8'h80, 8'h41}
  };

  logic clk = 1'b0, rst_n = 1'b0, us_tick = 1'b0, start = 1'b0, start_unit = 1'b0;
  logic [7:0] start_mask = 8'h00, stat_data = 8'h00;
  logic stat_rd, dsel_wr, busy, done;
  logic [7:0] dsel_data;
  logic [2:0] result;

  ready_wait_poller #(
    .BUSY_BUDGET_US(BUDGET), .FINE_LIMIT_US(FLIM), .FINE_STEP_US(FSTEP),
    .COARSE_STEP_US(CSTEP), .FLOAT_PENALTY_US(PEN), .FLOAT_WAIT_US(FWAIT),
    .MASK_TRIES(TRIES), .MASK_STEP_US(MSTEP), .SETTLE_US(SETTLE)
  ) dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .start(start),
    .start_mask(start_mask), .start_unit(start_unit), .stat_rd(stat_rd),
    .stat_data(stat_data), .dsel_wr(dsel_wr), .dsel_data(dsel_data),
    .busy(busy), .done(done), .result(result)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  bit [63:0] cur = '0;
  int k = 0, nsel = 0, badsel = 0, nticks = 0, ndone = 0;
  logic [2:0] got = '0;

  function automatic logic [7:0] val(bit [63:0] v, int idx);
    int bc = int'(v[47:36]);
    int fc = int'(v[27:16]);
    if (idx < bc) return v[35:28];
    if (idx < bc + fc) return v[15:8];
    return v[7:0];
  endfunction

  task automatic model(input bit [63:0] v, output int res, output int reads,
                       output int sels, output int ticks);
    int acc = 0, tr = 0;
    logic [7:0] s = 8'h00, m;
    bit fin = 1'b0;
    m = v[55:48];
    res = 99; reads = 0; sels = 0; ticks = SETTLE;
    while (!fin) begin
      if (acc >= BUDGET) begin res = -2; fin = 1'b1; end
      else begin
        s = val(v, reads); reads++;
        if (s == 8'hFF) begin sels++; acc += PEN; ticks += FWAIT; end
        else if (!s[7]) fin = 1'b1;
        else if (acc > FLIM) begin acc += CSTEP; ticks += CSTEP; end
        else begin acc += FSTEP; ticks += FSTEP; end
      end
    end
    if (res != -2) begin
      if (m == 8'h00) res = int'(s[0]);
      else begin
        ticks += SETTLE;
        fin = 1'b0;
        while (!fin) begin
          s = val(v, reads); reads++; tr++;
          if ((s & m) == m) begin res = int'(s[0]); fin = 1'b1; end
          else begin
            ticks += MSTEP;
            if (tr == TRIES) begin res = -3; fin = 1'b1; end
          end
        end
      end
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      repeat (7) @(negedge clk);
      us_tick = 1'b1;
      @(negedge clk);
      us_tick = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (stat_rd) begin stat_data = val(cur, k); k++; end
    if (dsel_wr) begin
      nsel++;
      if (dsel_data != (8'hA0 | {3'b000, cur[56], 4'b0000})) badsel++;
    end
    if (busy && us_tick) nticks++;
    if (done) begin ndone++; got = result; end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic run_vec(input int idx, input bit [63:0] v, input bit poke);
    int er, erd, es, et, guard;
    model(v, er, erd, es, et);
    cur = v; k = 0; nsel = 0; badsel = 0; nticks = 0; ndone = 0;
    @(negedge clk);
    start = 1'b1; start_mask = v[55:48]; start_unit = v[56];
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk);
      start = 1'b1; start_mask = 8'h00; start_unit = ~v[56];
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (ndone == 0 && guard < 60000) begin @(negedge clk); guard++; end
    if (guard >= 60000) check(1'b0, "R1", $sformatf("vec %0d watchdog", idx), guard, 0);
    repeat (20) @(negedge clk);
    check(ndone == 1, "R1", $sformatf("vec %0d done pulses", idx), ndone, 1);
    check(got == 3'(er), (er < 0) ? (er == -2 ? "R5" : "R8") : (v[55:48] == 0 ? "R6" : "R7"),
          $sformatf("vec %0d result", idx), int'($signed(got)), er);
    check(k == erd, "R2", $sformatf("vec %0d reads", idx), k, erd);
    check(nsel == es && badsel == 0, "R4", $sformatf("vec %0d reselects", idx), nsel, es);
    check(nticks == et, "R3", $sformatf("vec %0d ticks start-to-done", idx), nticks, et);
    if (poke) check(ndone == 1 && k == erd && nticks == et, "R9",
                    "start while busy ignored", k, erd);
  endtask

  initial begin
    int kk;
    repeat (4) @(negedge clk);
    check(!busy && !done && !stat_rd && !dsel_wr, "R10", "reset state",
          int'({busy, done, stat_rd, dsel_wr}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !stat_rd && !dsel_wr, "R2", "idle quiet",
          int'({busy, stat_rd, dsel_wr}), 0);
    for (int i = 0; i < NV; i++) run_vec(i, VEC[i], 1'b0);
    run_vec(NV, VEC[2], 1'b1);
    // R10: reset in the middle of a long wait
    cur = VEC[7]; k = 0; ndone = 0;
    @(negedge clk);
    start = 1'b1; start_mask = 8'h00; start_unit = 1'b0;
    @(negedge clk);
    start = 1'b0;
    repeat (500) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(!busy && !done && !stat_rd && !dsel_wr, "R10", "mid-wait reset idles",
          int'({busy, done, stat_rd, dsel_wr}), 0);
    rst_n = 1'b1;
    kk = k;
    repeat (3000) @(negedge clk);
    check(ndone == 0 && k == kk && !busy, "R10", "no activity after reset", k, kk);
    finish_run();
  end

  initial begin
    #1000000;
    check(1'b0, "R1", "global watchdog", 0, 1);
    finish_run();
  end

endmodule